// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Synthesizer

This block produces the one-bit load-modulation stream of a 44-bit frequency-shift-keyed proximity tag. Each half of a Manchester bit is a burst of subcarrier cycles: either a fast burst with a period of eight carrier cycles or a slow burst with a period of ten. A strobe marks each carrier cycle, and the block emits one new sample on each strobe.

Software or a control block loads an identifier and raises the enable. The block then builds the frame from the identifier and sends it again and again with no gap between frames. Each frame has three parts: a start marker made of Manchester pairs that are not valid data, a short separator before every group of four data bits, and the 44 data bits with the most significant bit first. A new identifier that arrives during a frame is held back. It is used from the next frame onward, so a frame never mixes bits from two identifiers.

Top module: `fsk_tag_synth`

## Requirements
- R1: A fast half-bit is 48 samples: the 8-sample cycle 1,1,0,0,0,0,0,0 sent six times.
- R2: A slow half-bit is 50 samples: the 10-sample cycle 1,1,1,0,0,0,0,0,0,0 sent five times.
- R3: Every frame opens with eight half-bits in this order: fast, fast, fast, slow, slow, slow, fast, slow.
- R4: One 8-sample fast cycle (1,1,0,0,0,0,0,0) is sent as a separator before data bits 43, 39, 35, and so on down to bit 3. That makes eleven separators per frame.
- R5: The data bits follow the marker from bit 43 down to bit 0. A 1 is a slow half-bit followed by a fast one. A 0 is a fast half-bit followed by a slow one.
- R6: After bit 0 the next sample is the first sample of a new start marker. The frame is 4792 samples long.
- R7: A pulse on `id_load` captures `id_value`. While enabled, the captured value is used from the next frame onward, and the frame in progress is not affected.
- R8: While `enable` is low, `wave` is 0 from the next clock on. The frame position is reset, and any captured identifier becomes active. The first strobe after `enable` rises emits the first sample of a start marker.
- R9: `wave` changes only on a clock where both `strobe` and `enable` are high. Between strobes it holds its value.
- R10: After reset, `wave` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the modulation stream. When low, forces `wave` to 0 and restarts the frame |
| strobe | input | 1 | One pulse per carrier cycle; advances the stream by one sample |
| id_load | input | 1 | Capture `id_value` on this clock |
| id_value | input | 44 | Identifier to send, bit 43 first |
| wave | output | 1 | Registered modulation sample |

## Verification
The assertions make no assumption about how often `strobe` pulses. It may stay high for many clocks in a row, and the hold and restart properties still apply. They also allow `enable` and `id_load` to change on any clock. The frame-freeze property relies only on the identifier register changing at a frame wrap or while the block is disabled. The bench drives the strobe on every other clock so that the hold behaviour is exercised. It changes `enable` and `id_load` away from the active clock edge. It loads one identifier while disabled and a second one 500 samples into a frame, well away from any wrap, so the sample at which the switch is expected is known exactly.

// File: rtl/fsk_synth_pkg.sv
// Shared types for the FSK tag waveform synthesizer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package fsk_synth_pkg;

    // Kind of subcarrier burst being emitted
    typedef enum logic [1:0] {
        SEG_FAST = 2'd0,   // six 8-sample cycles
        SEG_SLOW = 2'd1,   // five 10-sample cycles
        SEG_SEP  = 2'd2    // single 8-sample cycle before a group of data bits
    } seg_kind_t;

    // Position within the frame
    typedef enum logic [1:0] {
        ST_MARK  = 2'd0,
        ST_SEP   = 2'd1,
        ST_HALF0 = 2'd2,
        ST_HALF1 = 2'd3
    } stage_t;

endpackage

// File: rtl/fsk_burst_gen.sv
// Subcarrier burst generator.
// Emits one sample per step for the burst kind selected by the sequencer.
// A burst is REP cycles of a DIV-sample pattern whose first HIGH samples are 1.
// Raises seg_done on the step that emits the last sample of a burst.
// Assumes: kind changes only when the counters are at zero (after seg_done or clear).
module fsk_burst_gen
    import fsk_synth_pkg::*;
#(
    parameter int DIV_FAST  = 8,
    parameter int HIGH_FAST = 2,
    parameter int REP_FAST  = 6,
    parameter int DIV_SLOW  = 10,
    parameter int HIGH_SLOW = 3,
    parameter int REP_SLOW  = 5,
    parameter int REP_SEP   = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      step,
    input  seg_kind_t kind,
    output logic      sample,
    output logic      seg_done
);

    localparam int MAX_DIV   = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int MAX_REP_A = (REP_FAST > REP_SLOW) ? REP_FAST : REP_SLOW;
    localparam int MAX_REP   = (MAX_REP_A > REP_SEP) ? MAX_REP_A : REP_SEP;
    localparam int PH_W      = $clog2(MAX_DIV + 1);
    localparam int RP_W      = $clog2(MAX_REP + 1);

    logic [PH_W-1:0] phase;
    logic [RP_W-1:0] rep;
    logic [PH_W-1:0] period_m1;
    logic [PH_W-1:0] high_cnt;
    logic [RP_W-1:0] reps_m1;
    logic            phase_end;
    logic            burst_last;

    // Select the pattern geometry for the current burst kind
    always_comb begin
        case (kind)
            SEG_SLOW: begin
                period_m1 = PH_W'(DIV_SLOW - 1);
                high_cnt  = PH_W'(HIGH_SLOW);
                reps_m1   = RP_W'(REP_SLOW - 1);
            end
            SEG_SEP: begin
                period_m1 = PH_W'(DIV_FAST - 1);
                high_cnt  = PH_W'(HIGH_FAST);
                reps_m1   = RP_W'(REP_SEP - 1);
            end
            default: begin
                period_m1 = PH_W'(DIV_FAST - 1);
                high_cnt  = PH_W'(HIGH_FAST);
                reps_m1   = RP_W'(REP_FAST - 1);
            end
        endcase
    end

    // Sample value and end-of-burst decode
    always_comb begin
        sample     = (phase < high_cnt);
        phase_end  = (phase == period_m1);
        burst_last = phase_end && (rep == reps_m1);
        seg_done   = step && burst_last;
    end

    // Advance phase within a cycle and count cycles within the burst
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase <= '0;
            rep   <= '0;
        end else if (step) begin
            if (phase_end) begin
                phase <= '0;
                rep   <= burst_last ? '0 : rep + RP_W'(1);
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    AST_PHASE_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= period_m1);                                         // R2
    AST_REP_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        rep <= reps_m1);                                             // R1

endmodule

// File: rtl/fsk_frame_seq.sv
// Frame sequencer.
// Walks the start marker, then for each identifier bit (MSB first) an optional
// group separator and two Manchester half-bits. Tells the burst generator which
// burst kind to emit, and flags frame_wrap on the last step of the frame.
// Assumes: GROUP is a power of two; id_bits is stable within a frame.
module fsk_frame_seq
    import fsk_synth_pkg::*;
#(
    parameter int ID_W     = 44,
    parameter int GROUP    = 4,
    parameter int MARK_LEN = 8,
    // bit i set: marker half-bit i is a slow burst, else fast
    parameter logic [MARK_LEN-1:0] MARK_PAT = 8'b1011_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            seg_done,
    input  logic [ID_W-1:0] id_bits,
    output seg_kind_t       kind,
    output logic            frame_wrap
);

    localparam int IDX_W = $clog2(ID_W);
    localparam int MK_W  = $clog2(MARK_LEN);
    localparam int GRP_W = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(ID_W - 1);
    localparam logic [MK_W-1:0]  MARK_LAST = MK_W'(MARK_LEN - 1);

    stage_t           stage;
    logic [MK_W-1:0]  mark_idx;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] nxt_idx;
    logic             cur_bit;

    // True when a separator precedes the bit at this index
    function automatic logic sep_before(input logic [IDX_W-1:0] idx);
        return idx[GRP_W-1:0] == GRP_W'(GROUP - 1);
    endfunction

    // Decode the current burst kind from the frame position
    always_comb begin
        cur_bit = id_bits[bit_idx];
        nxt_idx = bit_idx - IDX_W'(1);
        case (stage)
            ST_MARK:  kind = MARK_PAT[mark_idx] ? SEG_SLOW : SEG_FAST;
            ST_SEP:   kind = SEG_SEP;
            ST_HALF0: kind = cur_bit ? SEG_SLOW : SEG_FAST;
            default:  kind = cur_bit ? SEG_FAST : SEG_SLOW;
        endcase
        frame_wrap = seg_done && (stage == ST_HALF1) && (bit_idx == '0);
    end

    // Step to the next frame position at the end of each burst
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            stage    <= ST_MARK;
            mark_idx <= '0;
            bit_idx  <= TOP_IDX;
        end else if (seg_done) begin
            case (stage)
                ST_MARK: begin
                    if (mark_idx == MARK_LAST) begin
                        mark_idx <= '0;
                        bit_idx  <= TOP_IDX;
                        stage    <= sep_before(TOP_IDX) ? ST_SEP : ST_HALF0;
                    end else begin
                        mark_idx <= mark_idx + MK_W'(1);
                    end
                end
                ST_SEP:   stage <= ST_HALF0;
                ST_HALF0: stage <= ST_HALF1;
                default: begin
                    if (bit_idx == '0) begin
                        stage   <= ST_MARK;
                        bit_idx <= TOP_IDX;
                    end else begin
                        bit_idx <= nxt_idx;
                        stage   <= sep_before(nxt_idx) ? ST_SEP : ST_HALF0;
                    end
                end
            endcase
        end
    end

    AST_SEP_ON_GROUP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_SEP) |-> (bit_idx[GRP_W-1:0] == GRP_W'(GROUP - 1)));   // R4
    AST_WRAP_RESTARTS_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (stage == ST_MARK && mark_idx == '0));              // R6

endmodule

// File: rtl/fsk_id_hold.sv
// Identifier double buffer.
// Captures a loaded identifier into a pending register and copies it into the
// active register only when the frame wraps or the block is idle.
// Assumes: take is asserted exactly at frame boundaries or while disabled.
module fsk_id_hold #(
    parameter int ID_W = 44
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ID_W-1:0] id_in,
    input  logic            take,
    output logic [ID_W-1:0] active
);

    logic [ID_W-1:0] pending;

    // Capture new identifiers and promote them at frame boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            active  <= '0;
        end else begin
            if (load) pending <= id_in;
            if (take) active  <= pending;
        end
    end

    AST_ID_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(active));                                  // R7

endmodule

// File: rtl/fsk_tag_synth.sv
// FSK proximity tag waveform synthesizer (top).
// Builds a repeating frame of marker, separators and Manchester-coded
// identifier bits out of fast and slow subcarrier bursts, one sample per strobe.
// Assumes: strobe is one clock wide per carrier cycle (back-to-back is allowed).
module fsk_tag_synth
    import fsk_synth_pkg::*;
#(
    parameter int ID_W = 44
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            strobe,
    input  logic            id_load,
    input  logic [ID_W-1:0] id_value,
    output logic            wave
);

    logic            step;
    logic            idle;
    logic            sample;
    logic            seg_done;
    logic            frame_wrap;
    seg_kind_t       kind;
    logic [ID_W-1:0] active_id;

    // Qualify the carrier strobe with the enable
    always_comb begin
        step = enable && strobe;
        idle = !enable;
    end

    fsk_id_hold #(.ID_W(ID_W)) u_id (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (id_load),
        .id_in  (id_value),
        .take   (frame_wrap || idle),
        .active (active_id)
    );

    fsk_frame_seq #(.ID_W(ID_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (idle),
        .seg_done   (seg_done),
        .id_bits    (active_id),
        .kind       (kind),
        .frame_wrap (frame_wrap)
    );

    fsk_burst_gen u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idle),
        .step     (step),
        .kind     (kind),
        .sample   (sample),
        .seg_done (seg_done)
    );

    // Register the output sample on each qualified strobe
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            wave <= 1'b0;
        end else if (step) begin
            wave <= sample;
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !wave);                                          // R8
    AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !strobe) |=> $stable(wave));                      // R9

endmodule

// File: tb/tb_fsk_tag_synth.sv
module tb_fsk_tag_synth;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W       = 44;
    localparam int FRAME_LEN  = 4792;
    localparam int WATCHDOG   = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic            strobe = 1'b0;
    logic            run_strobe = 1'b0;
    logic            id_load = 1'b0;
    logic [ID_W-1:0] id_value = '0;
    logic            wave;

    int    checks = 0;
    int    fails  = 0;
    bit    q_val[$];
    string q_tag[$];

    fsk_tag_synth #(.ID_W(ID_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .strobe   (strobe),
        .id_load  (id_load),
        .id_value (id_value),
        .wave     (wave)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // strobe on every other clock, changed away from the active edge
    initial forever begin
        @(negedge clk);
        strobe = run_strobe ? ~strobe : 1'b0;
    end

    task automatic check(input bit ok, input string tag, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: wave=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: expected bursts
    task automatic push_burst(input int per, input int hi, input int reps, input string tag);
        for (int r = 0; r < reps; r++)
            for (int p = 0; p < per; p++) begin
                q_val.push_back(p < hi);
                q_tag.push_back(tag);
            end
    endtask

    task automatic push_frame(input logic [ID_W-1:0] id, input string pre);
        int mk[8] = '{8, 8, 8, 10, 10, 10, 8, 10};
        for (int m = 0; m < 8; m++) begin
            if (mk[m] == 8) push_burst(8, 2, 6, {pre, "R3,R1"});
            else            push_burst(10, 3, 5, {pre, "R3,R2"});
        end
        for (int b = ID_W - 1; b >= 0; b--) begin
            if (b % 4 == 3) push_burst(8, 2, 1, {pre, "R4"});
            if (id[b]) begin
                push_burst(10, 3, 5, {pre, "R5,R2"});
                push_burst(8, 2, 6, {pre, "R5,R1"});
            end else begin
                push_burst(8, 2, 6, {pre, "R5,R1"});
                push_burst(10, 3, 5, {pre, "R5,R2"});
            end
        end
    endtask

    task automatic load_id(input logic [ID_W-1:0] v);
        @(negedge clk);
        id_value = v;
        id_load  = 1'b1;
        @(negedge clk);
        id_load  = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    // monitor: pop and compare on every strobe, check quiet and hold otherwise
    logic st_s, en_s, prev_wave;
    bit   exp_v;
    string exp_t;
    initial begin
        prev_wave = 1'b0;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            st_s = strobe;
            en_s = enable;
            @(negedge clk);
            if (!en_s) begin
                check(wave == 1'b0, "R8 disabled", wave, 1'b0);
            end else if (st_s) begin
                if (q_val.size() > 0) begin
                    exp_v = q_val.pop_front();
                    exp_t = q_tag.pop_front();
                    check(wave == exp_v, exp_t, wave, exp_v);
                end
            end else begin
                check(wave == prev_wave, "R9 hold", wave, prev_wave);
            end
            prev_wave = wave;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog: actual running expected finished");
        finish_run();
    end

    localparam logic [ID_W-1:0] ID_A = 44'hB6D_31A5_9E4C;
    localparam logic [ID_W-1:0] ID_B = 44'h50F_C3A0_17E2;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wave == 1'b0, "R10 reset", wave, 1'b0);

        // disabled with strobes running: quiet output (R8)
        run_strobe = 1'b1;
        repeat (20) @(negedge clk);

        // load while idle, then two frames of A back to back (R6)
        load_id(ID_A);
        repeat (3) @(negedge clk);
        push_frame(ID_A, "");
        push_frame(ID_A, "R6 ");
        @(negedge clk);
        enable = 1'b1;

        // load B 500 samples into the second frame: applies from the third (R7)
        while (q_val.size() > FRAME_LEN - 500) @(negedge clk);
        load_id(ID_B);
        push_frame(ID_B, "R7 ");
        while (q_val.size() > 0) @(negedge clk);

        // drop enable mid-frame, then restart from the marker (R8)
        repeat (300) @(negedge clk);
        enable = 1'b0;
        repeat (40) @(negedge clk);
        push_frame(ID_B, "R8 ");
        enable = 1'b1;
        while (q_val.size() > 0) @(negedge clk);
        repeat (6) @(negedge clk);
        enable = 1'b0;
        repeat (6) @(negedge clk);
        finish_run();
    end

endmodule